// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block is the front end for eight external interrupt request pins. Each pin first passes through a two-flop synchronizer. The block then checks the pin against the condition that software selected for it: a falling edge, a rising edge, a low level or a high level. When that condition is met, the block records a pending request for the pin. A 32-bit control register holds a 2-bit sense code for each pin. The upper sixteen bits carry the codes and the lower sixteen bits are reserved.

The pins form two groups of four. Each group has its own mode-enable input, and a disabled group produces no requests. A hold-mode input controls how level requests behave:

- With the input low, a level request is latched until software masks the pin.
- With the input high, a level request follows the synchronized pin.

Edge requests stay pending until the CPU acknowledges them or masks the pin. The pending outputs go to an interrupt priority stage, which is not part of this block.

All pins and control inputs are plain signals, not streams. There is no valid/ready handshake and no back-pressure. Register writes take effect on the clock edge where `cfg_we` is high. The read data port always shows the current register contents.

Top module: `irqs_front`

## Requirements
- R1: After reset the register reads 0x0000_0000 and every bit of `irq_pend` is 0.
- R2: The sense code of pin i sits in register bits [31-2i : 30-2i], so pin 0 uses bits 31:30 and pin 7 uses bits 17:16. A written code reads back unchanged.
- R3: Register bits 15:0 always read as zero, and writes to them have no effect.
- R4: Code 00 sets a pending request on a falling edge and code 01 sets one on a rising edge. An edge request stays pending after the pin settles, and a one-cycle `irq_ack` pulse for that pin clears it. An edge of the opposite direction sets nothing.
- R5: When `lvl_follow` is 1, code 10 requests while the pin is low and code 11 requests while the pin is high. The request drops once the pin becomes inactive.
- R6: When `lvl_follow` is 0, a level request stays pending after the pin returns to its inactive level. `irq_ack` does not clear it.
- R7: While `irq_mask[i]` is 1, `irq_pend[i]` is 0. Setting the mask bit clears the pending state in any mode. An event that happens while the pin is masked is not remembered after the mask is removed.
- R8: Pins 3..0 request only while `grp_en_lo` is 1, and pins 7..4 only while `grp_en_hi` is 1. Disabling a group clears the pending state of its pins.
- R9: A pin change that meets the selected condition shows on `irq_pend` after exactly three rising clock edges (two synchronizer stages plus the pending flop), and not after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| grp_en_lo | input | 1 | Enables sensing on pins 3..0 |
| grp_en_hi | input | 1 | Enables sensing on pins 7..4 |
| lvl_follow | input | 1 | 1: level requests follow the pin; 0: level requests are latched |
| irq_mask | input | 8 | Per-pin mask; 1 blocks and clears the pin's request |
| irq_ack | input | 8 | Per-pin CPU acknowledge pulse |
| irq_pin | input | 8 | Asynchronous request pins |
| irq_pend | output | 8 | Per-pin pending request |

## Verification
The bench measures synchronizer latency at both the two-edge and the three-edge point. A design with one stage too many or too few fails one of these two checks.

It checks that an edge request survives after the pin settles and that an opposite edge sets nothing. A design that treated edges as levels would lose the first and fire on the second.

For latched level requests it applies an acknowledge pulse and expects no effect, then sets the mask and expects the request to clear. A design that let the acknowledge clear the request, or ignored the mask, would show it.

Events that occur while a pin is masked, and requests in a group whose enable drops, must leave nothing pending afterwards. A design that kept stale state would raise a spurious request.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int unsigned SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SNS_FALL = 2'b00,
    SNS_RISE = 2'b01,
    SNS_LOW  = 2'b10,
    SNS_HIGH = 2'b11
  } sense_e;
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/irqs_detect.sv
module irqs_detect
  import irqs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cur,
  input  logic   prev,
  input  sense_e code,
  input  logic   en,
  input  logic   follow,
  input  logic   mask,
  input  logic   ack,
  output logic   pend
);
  logic edge_mode, edge_hit, lvl_hit, hit, pend_q, pend_d;

  assign edge_mode = (code == SNS_FALL) || (code == SNS_RISE);
  assign edge_hit  = (code == SNS_RISE) ? (cur & ~prev) : (~cur & prev);
  assign lvl_hit   = (code == SNS_HIGH) ? cur : ~cur;
  assign hit       = edge_mode ? edge_hit : lvl_hit;

  always_comb begin
    if (!en || mask)    pend_d = 1'b0;
    else if (edge_mode) pend_d = hit | (pend_q & ~ack);
    else if (follow)    pend_d = hit;
    else                pend_d = hit | pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irqs_front.sv
module irqs_front
  import irqs_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned REG_W = 32,
  parameter int unsigned GRP_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             grp_en_lo,
  input  logic             grp_en_hi,
  input  logic             lvl_follow,
  input  logic [NPINS-1:0] irq_mask,
  input  logic [NPINS-1:0] irq_ack,
  input  logic [NPINS-1:0] irq_pin,
  output logic [NPINS-1:0] irq_pend
);
  localparam int unsigned FIELD_BITS = NPINS * SENSE_W;
  localparam int unsigned RSV_BITS   = REG_W - FIELD_BITS;
  localparam logic [REG_W-1:0] KEEP_MASK = {{FIELD_BITS{1'b1}}, {RSV_BITS{1'b0}}};

  logic [REG_W-1:0] reg_q;
  logic [NPINS-1:0] s_cur, s_prev, pend_q, pin_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (cfg_we) reg_q <= cfg_wdata & KEEP_MASK;
  end

  assign cfg_rdata = reg_q;

  irqs_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (irq_pin),
    .cur  (s_cur),
    .prev (s_prev)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      // Low group enable serves pins 0..GRP_N-1; high serves the rest.
      if (i < GRP_N) begin : g_lo
        assign pin_en[i] = grp_en_lo;
      end else begin : g_hi
        assign pin_en[i] = grp_en_hi;
      end

      irqs_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (s_cur[i]),
        .prev  (s_prev[i]),
        .code  (sense_e'(reg_q[REG_W-1-SENSE_W*i -: SENSE_W])),
        .en    (pin_en[i]),
        .follow(lvl_follow),
        .mask  (irq_mask[i]),
        .ack   (irq_ack[i]),
        .pend  (pend_q[i])
      );
    end
  endgenerate

  assign irq_pend = pend_q & ~irq_mask & pin_en;
endmodule

// File: rtl/irqs_front_chk.sv
module irqs_front_chk #(
  parameter int unsigned NPINS = 8,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] cfg_rdata,
  input logic [REG_W-1:0] reg_q,
  input logic             lvl_follow,
  input logic [NPINS-1:0] irq_mask,
  input logic [NPINS-1:0] s_cur,
  input logic [NPINS-1:0] s_prev,
  input logic [NPINS-1:0] pin_en,
  input logic [NPINS-1:0] pend_q,
  input logic [NPINS-1:0] irq_pend
);
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-NPINS*2-1:0] == '0);

  a_r7_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend & irq_mask) == '0);

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_chk
      // R4: a rising edge under code 01 sets the pending flop
      a_r4_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en[i] && !irq_mask[i] && reg_q[REG_W-1-2*i -: 2] == 2'b01
         && s_cur[i] && !s_prev[i]) |=> pend_q[i]);

      // R6: a latched level request persists while unmasked and enabled
      a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en[i] && !irq_mask[i] && !lvl_follow && reg_q[REG_W-1-2*i]
         && pend_q[i]) |=> pend_q[i]);

      a_r7_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask[i] |=> !pend_q[i]);

      a_r8_group_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en[i] |=> !pend_q[i]);
    end
  endgenerate
endmodule

bind irqs_front irqs_front_chk #(.NPINS(NPINS), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .reg_q     (reg_q),
  .lvl_follow(lvl_follow),
  .irq_mask  (irq_mask),
  .s_cur     (s_cur),
  .s_prev    (s_prev),
  .pin_en    (pin_en),
  .pend_q    (pend_q),
  .irq_pend  (irq_pend)
);

// File: tb/irqs_front_test.sv
module irqs_front_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        grp_en_lo, grp_en_hi, lvl_follow;
  logic [7:0]  irq_mask, irq_ack, irq_pin, irq_pend;
  logic [31:0] shadow;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqs_front uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .grp_en_lo(grp_en_lo), .grp_en_hi(grp_en_hi),
    .lvl_follow(lvl_follow), .irq_mask(irq_mask), .irq_ack(irq_ack),
    .irq_pin(irq_pin), .irq_pend(irq_pend)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; grp_en_lo = 1'b0; grp_en_hi = 1'b0;
    lvl_follow = 1'b0; irq_mask = '0; irq_ack = '0; irq_pin = '0; shadow = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic write_reg(input logic [31:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_sense(input int pin, input logic [1:0] code);
    shadow[31-2*pin -: 2] = code;
    write_reg(shadow);
  endtask

  task automatic ack_pulse(input int pin);
    irq_ack[pin] = 1'b1;
    cyc(1);
    irq_ack[pin] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reg after reset", cfg_rdata, 32'h0);
    check("R1 pend after reset", {24'h0, irq_pend}, 32'h0);
  endtask

  task automatic t_regs();
    do_reset();
    write_reg(32'hFFFF_FFFF);
    check("R3 reserved bits read zero", cfg_rdata, 32'hFFFF_0000);
    write_reg(32'h4003_ABCD);
    check("R2 pin0=01 pin7=11 layout", cfg_rdata, 32'h4003_0000);
  endtask

  task automatic t_latency();
    do_reset();
    grp_en_lo = 1'b1;
    set_sense(2, 2'b01);
    irq_pin[2] = 1'b1;
    cyc(2);
    check("R9 not yet after two edges", {31'h0, irq_pend[2]}, 32'h0);
    cyc(1);
    check("R9 visible after three edges", {31'h0, irq_pend[2]}, 32'h1);
    ack_pulse(2);
    check("R4 ack clears rise request", {31'h0, irq_pend[2]}, 32'h0);
    irq_pin[2] = 1'b0;
    cyc(4);
    check("R4 falling edge ignored in rise mode", {31'h0, irq_pend[2]}, 32'h0);
  endtask

  task automatic t_edges();
    do_reset();
    grp_en_lo = 1'b1;
    set_sense(1, 2'b00);
    irq_pin[1] = 1'b1;
    cyc(4);
    check("R4 rising edge ignored in fall mode", {31'h0, irq_pend[1]}, 32'h0);
    irq_pin[1] = 1'b0;
    cyc(4);
    check("R4 falling edge sets pending", {31'h0, irq_pend[1]}, 32'h1);
    cyc(5);
    check("R4 edge request persists", {31'h0, irq_pend[1]}, 32'h1);
    ack_pulse(1);
    check("R4 ack clears fall request", {31'h0, irq_pend[1]}, 32'h0);
  endtask

  task automatic t_level_follow();
    do_reset();
    grp_en_lo = 1'b1; grp_en_hi = 1'b1; lvl_follow = 1'b1;
    set_sense(0, 2'b10);
    cyc(2);
    check("R5 low level requests", {31'h0, irq_pend[0]}, 32'h1);
    irq_pin[0] = 1'b1;
    cyc(4);
    check("R5 low request drops when pin high", {31'h0, irq_pend[0]}, 32'h0);
    set_sense(6, 2'b11);
    irq_pin[6] = 1'b1;
    cyc(4);
    check("R5 high level requests", {31'h0, irq_pend[6]}, 32'h1);
    irq_pin[6] = 1'b0;
    cyc(4);
    check("R5 high request drops when pin low", {31'h0, irq_pend[6]}, 32'h0);
  endtask

  task automatic t_level_latched();
    do_reset();
    grp_en_lo = 1'b1;
    set_sense(3, 2'b11);
    irq_pin[3] = 1'b1;
    cyc(4);
    check("R6 high level latched", {31'h0, irq_pend[3]}, 32'h1);
    irq_pin[3] = 1'b0;
    cyc(5);
    check("R6 held after pin inactive", {31'h0, irq_pend[3]}, 32'h1);
    ack_pulse(3);
    cyc(1);
    check("R6 ack does not clear level", {31'h0, irq_pend[3]}, 32'h1);
    irq_mask[3] = 1'b1;
    cyc(1);
    check("R7 mask hides held request", {31'h0, irq_pend[3]}, 32'h0);
    irq_mask[3] = 1'b0;
    cyc(2);
    check("R7 mask cleared held request", {31'h0, irq_pend[3]}, 32'h0);
  endtask

  task automatic t_mask();
    do_reset();
    grp_en_lo = 1'b1;
    set_sense(1, 2'b01);
    irq_mask[1] = 1'b1;
    irq_pin[1] = 1'b1;
    cyc(4);
    check("R7 masked edge hidden", {31'h0, irq_pend[1]}, 32'h0);
    irq_mask[1] = 1'b0;
    cyc(3);
    check("R7 masked edge not remembered", {31'h0, irq_pend[1]}, 32'h0);
    irq_pin[1] = 1'b0;
    cyc(4);
    irq_pin[1] = 1'b1;
    cyc(4);
    check("R7 unmasked edge pending", {31'h0, irq_pend[1]}, 32'h1);
    irq_mask[1] = 1'b1;
    cyc(1);
    irq_mask[1] = 1'b0;
    cyc(1);
    check("R7 mask pulse clears edge request", {31'h0, irq_pend[1]}, 32'h0);
  endtask

  task automatic t_groups();
    do_reset();
    lvl_follow = 1'b1;
    set_sense(5, 2'b11);
    irq_pin[5] = 1'b1;
    cyc(4);
    check("R8 high group off blocks pin5", {31'h0, irq_pend[5]}, 32'h0);
    grp_en_hi = 1'b1;
    cyc(2);
    check("R8 high group on passes pin5", {31'h0, irq_pend[5]}, 32'h1);
    check("R8 low pins idle", {28'h0, irq_pend[3:0]}, 32'h0);
    grp_en_lo = 1'b1;
    set_sense(2, 2'b01);
    irq_pin[2] = 1'b1;
    cyc(4);
    check("R8 low group pin2 edge pending", {31'h0, irq_pend[2]}, 32'h1);
    grp_en_lo = 1'b0;
    cyc(2);
    grp_en_lo = 1'b1;
    cyc(2);
    check("R8 disabling group cleared pin2", {31'h0, irq_pend[2]}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_latency();
    t_edges();
    t_level_follow();
    t_level_latched();
    t_mask();
    t_groups();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule